// File: doc/BRIEF.md
# Packed Byte Multiply-Add and Rounding Multiplier

This unit performs one of two packed multiply operations on a pair of operands, A and B, each up to 128 bits wide. The first operation treats every byte of A as unsigned and every byte of B as signed. It multiplies the bytes in matching positions, then adds each pair of neighbouring products into one signed 16-bit word. Each word is clamped to the signed 16-bit range. The second operation treats both operands as signed 16-bit lanes. For each lane it forms the full product, adds a rounding constant, and keeps the high part, which is the Q15 fixed-point product rounded to nearest.

A one-cycle `start_i` pulse launches an operation. The operation code and the width flag are sampled in the same cycle. The result is registered. It appears together with a one-cycle `done_o` strobe on the next cycle, and it stays unchanged until the next start. A new start may be given in every cycle. When the width flag is low, only the lower 64 bits of each operand take part.

Top module: `simd_mul_unit`

## Requirements
- R1: With `op_i` = 0x04, output word k (bits 16k+15:16k) equals the sum ua(2k)·sb(2k) + ua(2k+1)·sb(2k+1). Here byte j is bits 8j+7:8j, ua is that byte of A read as unsigned and sb is that byte of B read as signed.
- R2: In the 0x04 operation, a pair sum above 32767 gives 0x7FFF and a pair sum below -32768 gives 0x8000. For example, A bytes 0xFF with B bytes 0x7F give 0x7FFF, and A bytes 0xFF with B bytes 0x80 give 0x8000.
- R3: With `op_i` = 0x0B, output lane k (bits 16k+15:16k) is the low 16 bits of ((signed A lane × signed B lane) + 0x4000) shifted arithmetically right by 15.
- R4: In the 0x0B operation, 0x8000 × 0x8000 gives 0x8000 (it wraps and does not saturate).
- R5: With `wide_i` = 1, all eight 16-bit output lanes are computed. With `wide_i` = 0, only lanes 0 to 3 are computed from bits 63:0 of the operands. `res_o[127:64]` is then zero, and operand bits 127:64 have no effect.
- R6: `done_o` is high in exactly the cycle after each cycle with `start_i` high, and `res_o` holds that operation's result in that cycle. Starts in consecutive cycles each produce their own result one cycle later.
- R7: While `start_i` is low, `res_o` keeps its value regardless of the operand, operation code and width inputs.
- R8: Any `op_i` value other than 0x04 or 0x0B gives an all-zero `res_o`, and `done_o` still pulses.
- R9: While `rst_ni` is low, `res_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launches an operation on the sampled inputs |
| op_i | input | 8 | Operation code: 0x04 byte multiply-add, 0x0B rounding multiply |
| wide_i | input | 1 | 1 = 128-bit operands, 0 = 64-bit operands |
| a_i | input | 128 | Operand A (unsigned bytes or signed 16-bit lanes) |
| b_i | input | 128 | Operand B (signed bytes or signed 16-bit lanes) |
| res_o | output | 128 | Packed result |
| done_o | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench drives all-0xFF bytes against 0x7F and 0x80 bytes. A sum held in too few bits, or a clamp on the wrong side, would wrap those sums to wrong positive or negative values instead of 0x7FFF and 0x8000. The bench puts 0x8000 in both lanes of the rounding multiply, so a design that saturates there would return 0x7FFF. It also checks negative products, where a logical shift in place of an arithmetic one, or a missing rounding term, would be one step off or carry the wrong sign. Narrow mode is run with random upper operand bits: a design that lets them into lanes 4 to 7 would show non-zero upper words. Back-to-back starts and idle cycles with changing inputs catch a result that is dropped, repeated or overwritten.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;
  localparam int unsigned VEC_W_DEF  = 128;
  localparam int unsigned LANE_W_DEF = 16;
  localparam int unsigned OP_W       = 8;
  localparam logic [OP_W-1:0] OP_MADD = 8'h04;
  localparam logic [OP_W-1:0] OP_RMUL = 8'h0B;

  typedef enum logic [1:0] {
    SEL_ZERO = 2'd0,
    SEL_MADD = 2'd1,
    SEL_RMUL = 2'd2
  } op_sel_e;

  function automatic op_sel_e decode_op(input logic [OP_W-1:0] op);
    case (op)
      OP_MADD: return SEL_MADD;
      OP_RMUL: return SEL_RMUL;
      default: return SEL_ZERO;
    endcase
  endfunction
endpackage

// File: rtl/madd_lane.sv
// One output word: two unsigned-by-signed byte products summed, then clamped.
module madd_lane #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] sum_o
);
  localparam int unsigned BW = LANE_W / 2;
  localparam int unsigned SW = LANE_W + 2;  // 2*255*128 needs LANE_W+1 signed bits
  localparam logic signed [SW-1:0] HI_S = SW'((1 << (LANE_W - 1)) - 1);
  localparam logic signed [SW-1:0] LO_S = -HI_S - SW'(1);

  logic signed [SW-1:0] a0_x, a1_x, b0_x, b1_x, p0, p1, sum;

  always_comb begin
    a0_x = {{(SW-BW){1'b0}}, a_i[BW-1:0]};
    a1_x = {{(SW-BW){1'b0}}, a_i[LANE_W-1:BW]};
    b0_x = {{(SW-BW){b_i[BW-1]}}, b_i[BW-1:0]};
    b1_x = {{(SW-BW){b_i[LANE_W-1]}}, b_i[LANE_W-1:BW]};
    p0   = a0_x * b0_x;
    p1   = a1_x * b1_x;
    sum  = p0 + p1;
    if (sum > HI_S)      sum_o = {1'b0, {(LANE_W-1){1'b1}}};
    else if (sum < LO_S) sum_o = {1'b1, {(LANE_W-1){1'b0}}};
    else                 sum_o = sum[LANE_W-1:0];
  end
endmodule

// File: rtl/rmul_lane.sv
// Signed lane multiply, round half up, keep bits [2W-2:W-1] (wraps on min*min).
module rmul_lane #(
  parameter int unsigned LANE_W = 16
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  output logic [LANE_W-1:0] prod_o
);
  localparam int unsigned PW = 2 * LANE_W;
  localparam logic signed [PW-1:0] RND = PW'(1) << (LANE_W - 2);

  logic signed [PW-1:0] a_x, b_x, prod, rnd;

  always_comb begin
    a_x    = {{LANE_W{a_i[LANE_W-1]}}, a_i};
    b_x    = {{LANE_W{b_i[LANE_W-1]}}, b_i};
    prod   = a_x * b_x;
    rnd    = prod + RND;
    prod_o = rnd[PW-2:LANE_W-1];
  end
endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic              wide_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  output logic [VEC_W-1:0]  res_o,
  output logic              done_o
);
  localparam int unsigned NUM_LANES  = VEC_W / LANE_W;
  localparam int unsigned HALF_LANES = NUM_LANES / 2;

  op_sel_e          sel;
  logic [VEC_W-1:0] madd_v, rmul_v, res_d, res_q;
  logic             done_q;

  assign sel = decode_op(op_i);

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [LANE_W-1:0] madd_w, rmul_w;
    logic              lane_on;

    madd_lane #(.LANE_W(LANE_W)) u_madd (
      .a_i  (a_i[k*LANE_W +: LANE_W]),
      .b_i  (b_i[k*LANE_W +: LANE_W]),
      .sum_o(madd_w)
    );
    rmul_lane #(.LANE_W(LANE_W)) u_rmul (
      .a_i   (a_i[k*LANE_W +: LANE_W]),
      .b_i   (b_i[k*LANE_W +: LANE_W]),
      .prod_o(rmul_w)
    );

    if (k < HALF_LANES) begin : g_low
      assign lane_on = 1'b1;
    end else begin : g_high
      assign lane_on = wide_i;
    end

    assign madd_v[k*LANE_W +: LANE_W] = lane_on ? madd_w : '0;
    assign rmul_v[k*LANE_W +: LANE_W] = lane_on ? rmul_w : '0;
  end

  always_comb begin
    unique case (sel)
      SEL_MADD: res_d = madd_v;
      SEL_RMUL: res_d = rmul_v;
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= start_i;
      if (start_i) res_q <= res_d;
    end
  end

  assign res_o  = res_q;
  assign done_o = done_q;
endmodule

// File: rtl/simd_mul_unit_chk.sv
module simd_mul_unit_chk
  import simd_mul_pkg::*;
#(
  parameter int unsigned VEC_W  = VEC_W_DEF,
  parameter int unsigned LANE_W = LANE_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic              wide_i,
  input logic [VEC_W-1:0]  a_i,
  input logic [VEC_W-1:0]  b_i,
  input logic [VEC_W-1:0]  res_o,
  input logic              done_o
);
  localparam logic [LANE_W-1:0] MIN_W = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] MAX_W = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] B7F   = {(LANE_W/8){8'h7F}};

  assert_done_after_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);

  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !done_o);

  assert_hold_result_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(res_o));

  assert_narrow_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !wide_i) |=> (res_o[VEC_W-1:VEC_W/2] == '0));

  assert_bad_op_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i != OP_MADD && op_i != OP_RMUL) |=> (res_o == '0));

  assert_min_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_RMUL && a_i[LANE_W-1:0] == MIN_W && b_i[LANE_W-1:0] == MIN_W)
      |=> (res_o[LANE_W-1:0] == MIN_W));

  assert_sat_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == OP_MADD && a_i[LANE_W-1:0] == '1 && b_i[LANE_W-1:0] == B7F)
      |=> (res_o[LANE_W-1:0] == MAX_W));
endmodule

bind simd_mul_unit simd_mul_unit_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .op_i   (op_i),
  .wide_i (wide_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .res_o  (res_o),
  .done_o (done_o)
);

// File: tb/simd_mul_unit_bench.sv
module simd_mul_unit_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [7:0]   op_i = 8'h00;
  logic         wide_i = 1'b0;
  logic [127:0] a_i = '0;
  logic [127:0] b_i = '0;
  logic [127:0] res_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  simd_mul_unit u_simd_mul_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .wide_i(wide_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .done_o(done_o)
  );

  function automatic logic [127:0] ref_madd(input logic [127:0] a, input logic [127:0] b,
                                            input logic wide);
    logic [127:0] r = '0;
    int n = wide ? 8 : 4;
    for (int k = 0; k < n; k++) begin
      int s;
      s = int'(a[16*k +: 8]) * int'($signed(b[16*k +: 8]))
        + int'(a[16*k+8 +: 8]) * int'($signed(b[16*k+8 +: 8]));
      if (s > 32767) s = 32767;
      else if (s < -32768) s = -32768;
      r[16*k +: 16] = s[15:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] ref_rmul(input logic [127:0] a, input logic [127:0] b,
                                            input logic wide);
    logic [127:0] r = '0;
    int n = wide ? 8 : 4;
    for (int k = 0; k < n; k++) begin
      longint p;
      p = longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
      p = (p + 64'sd16384) >>> 15;
      r[16*k +: 16] = p[15:0];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Drive one start; returns at the negedge where the result is visible.
  task automatic issue(input logic [7:0] op, input logic wide,
                       input logic [127:0] a, input logic [127:0] b);
    @(negedge clk_i);
    op_i = op; wide_i = wide; a_i = a; b_i = b; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_reset_r9();
    check("R9 reset res", res_o, '0);
    check("R9 reset done", {127'd0, done_o}, '0);
  endtask

  task automatic t_madd_random_r1();
    for (int i = 0; i < 40; i++) begin
      logic [127:0] a = rnd128();
      logic [127:0] b = rnd128();
      issue(8'h04, 1'b1, a, b);
      check("R1 madd random", res_o, ref_madd(a, b, 1'b1));
      check("R6 done with madd", {127'd0, done_o}, 128'd1);
    end
    issue(8'h04, 1'b1, {16{8'h03}}, {8{8'hFE, 8'h05}});
    check("R1 madd mixed sign", res_o, ref_madd({16{8'h03}}, {8{8'hFE, 8'h05}}, 1'b1));
  endtask

  task automatic t_madd_sat_r2();
    issue(8'h04, 1'b1, {16{8'hFF}}, {16{8'h7F}});
    check("R2 sat high", res_o, {8{16'h7FFF}});
    issue(8'h04, 1'b1, {16{8'hFF}}, {16{8'h80}});
    check("R2 sat low", res_o, {8{16'h8000}});
    // one lane each side, rest just inside range: 0x80*0x7F*2 = 32512
    issue(8'h04, 1'b1, {{12{8'h80}}, {2{8'hFF}}, {2{8'hFF}}},
                       {{12{8'h7F}}, {2{8'h80}}, {2{8'h7F}}});
    check("R2 sat mixed", res_o, {{6{16'h7F00}}, 16'h8000, 16'h7FFF});
  endtask

  task automatic t_rmul_random_r3();
    for (int i = 0; i < 40; i++) begin
      logic [127:0] a = rnd128();
      logic [127:0] b = rnd128();
      issue(8'h0B, 1'b1, a, b);
      check("R3 rmul random", res_o, ref_rmul(a, b, 1'b1));
    end
    // -1 * 1 -> (-1 + 0x4000)>>>15 = 0 ; -3*0x4000 -> -0xC000+0x4000 = -0x8000 >>>15 = -1
    issue(8'h0B, 1'b1, {{6{16'h0000}}, 16'hFFFD, 16'hFFFF}, {{6{16'h1234}}, 16'h4000, 16'h0001});
    check("R3 rmul negative rounding", res_o, {{6{16'h0000}}, 16'hFFFF, 16'h0000});
  endtask

  task automatic t_rmul_wrap_r4();
    issue(8'h0B, 1'b1, {8{16'h8000}}, {8{16'h8000}});
    check("R4 min times min wraps", res_o, {8{16'h8000}});
  endtask

  task automatic t_narrow_r5();
    for (int i = 0; i < 20; i++) begin
      logic [127:0] a = rnd128();
      logic [127:0] b = rnd128();
      logic [7:0] op = i[0] ? 8'h0B : 8'h04;
      issue(op, 1'b0, a, b);
      check("R5 narrow", res_o, i[0] ? ref_rmul(a, b, 1'b0) : ref_madd(a, b, 1'b0));
    end
    issue(8'h04, 1'b0, {{8{8'hFF}}, {8{8'h01}}}, {{8{8'h7F}}, {8{8'h01}}});
    check("R5 narrow upper ignored", res_o, {64'd0, {4{16'h0002}}});
  endtask

  task automatic t_back_to_back_r6();
    logic [127:0] a1 = rnd128(), b1 = rnd128(), a2 = rnd128(), b2 = rnd128();
    @(negedge clk_i);
    op_i = 8'h04; wide_i = 1'b1; a_i = a1; b_i = b1; start_i = 1'b1;
    @(negedge clk_i);
    check("R6 first of pair", res_o, ref_madd(a1, b1, 1'b1));
    check("R6 done first", {127'd0, done_o}, 128'd1);
    op_i = 8'h0B; wide_i = 1'b0; a_i = a2; b_i = b2;
    @(negedge clk_i);
    start_i = 1'b0;
    check("R6 second of pair", res_o, ref_rmul(a2, b2, 1'b0));
    check("R6 done second", {127'd0, done_o}, 128'd1);
    @(negedge clk_i);
    check("R6 done falls", {127'd0, done_o}, '0);
  endtask

  task automatic t_hold_r7();
    logic [127:0] a = rnd128(), b = rnd128();
    logic [127:0] exp;
    issue(8'h0B, 1'b1, a, b);
    exp = ref_rmul(a, b, 1'b1);
    for (int i = 0; i < 4; i++) begin
      a_i = rnd128(); b_i = rnd128(); op_i = i[0] ? 8'h04 : 8'h55; wide_i = i[1];
      @(negedge clk_i);
      check("R7 hold while idle", res_o, exp);
      check("R7 no done while idle", {127'd0, done_o}, '0);
    end
  endtask

  task automatic t_bad_op_r8();
    logic [7:0] ops[4] = '{8'h00, 8'h05, 8'h0A, 8'hFF};
    foreach (ops[i]) begin
      issue(ops[i], 1'b1, {16{8'hFF}}, {16{8'h7F}});
      check("R8 unsupported op zero", res_o, '0);
      check("R8 done still pulses", {127'd0, done_o}, 128'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired checks=%0d", checks);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk_i);
    t_reset_r9();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_madd_random_r1();
    t_madd_sat_r2();
    t_rmul_random_r3();
    t_rmul_wrap_r4();
    t_narrow_r5();
    t_back_to_back_r6();
    t_hold_r7();
    t_bad_op_r8();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule